// File: doc/BRIEF.md
# MDIO Management Slave Controller

This block is the station-facing end of a two-wire management link on a PHY. The management clock (MDC) is the block clock. On each rising edge the block samples the bidirectional data line and parses one frame from it: a run of ones, a start pattern, a two-bit operation code, a five-bit device address, a five-bit register address, a two-bit turnaround and a sixteen-bit data field. When the device address matches the strap input and the operation is a read or a write, the block reads from or writes to a small bank of 16-bit registers. The set of implemented addresses is chosen by a parameter mask.

The line is driven only through an output enable. Nothing is driven outside the second turnaround bit and the data field of a matching read. Driven values change on the falling MDC edge, so they are steady when the station samples them on the next rising edge. Frames may follow one another with no idle bit between them.

Top module: `mdio_slave_top`

## Requirements
- R1: After reset `mdio_oe` is low, and every implemented register reads back as 16'h0000.
- R2: A frame is accepted only after at least 32 consecutive sampled ones followed by the bits 0 then 1. With 31 ones or fewer, the frame that follows is ignored and nothing is driven.
- R3: For a read (opcode bits 1 then 0), `mdio_oe` stays low during the first turnaround bit. It is high with `mdio_out` at 0 during the second turnaround bit. It stays high for the 16 data bits, which are sent bit 15 first. It is low again in the bit time after the last data bit.
- R4: For a write (opcode bits 0 then 1), the 16 data bits, sent bit 15 first, are stored in the addressed implemented register. Nothing is driven during the turnaround.
- R5: A read of an address whose bit in `IMPL_MASK` is clear returns 16'hFFFF, and the turnaround is driven as in R3. The default mask implements addresses 0 to 7 and 16.
- R6: A write to an address whose bit in `IMPL_MASK` is clear leaves every register unchanged.
- R7: A frame whose device address differs from `phy_addr` is ignored. Nothing is driven and no register changes.
- R8: A frame with opcode 00 or 11 is ignored. Nothing is driven and no register changes.
- R9: The preamble of a new frame may begin in the bit time that follows the last data bit of the previous frame, and that frame is handled normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock. Input is sampled on the rising edge and output changes on the falling edge. |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `mdc` |
| phy_addr | input | 5 | Strapped device address that is compared with the frame |
| mdio_in | input | 1 | Sampled level of the management data line |
| mdio_out | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Output enable for the data line. When low, the line is tri-stated. |

## Verification
Two functions can fall in the same cycle: the write commit on the final data bit of one frame, and the first preamble bit of the next frame. The frame table sends every frame back to back with no gap, and each write is followed at once by a read of the same address. The write has landed if the read returns the new word. The frame has been released correctly if `mdio_oe` stays low through the next preamble.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_AW = 5;
  localparam int REG_AW = 5;
  localparam int OP_W   = 2;
  localparam int HDR_W  = OP_W + PHY_AW + REG_AW;

  localparam logic [OP_W-1:0] OP_READ  = 2'b10;
  localparam logic [OP_W-1:0] OP_WRITE = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_HDR,
    ST_TA,
    ST_DATA,
    ST_SKIP
  } mdio_state_e;
endpackage

// File: rtl/mdio_rst_sync.sv
module mdio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic                 mdc,
  input  logic                 rst_n,
  input  logic                 mdio_in,
  input  logic [PHY_AW-1:0]    phy_addr,
  input  logic [DATA_W-1:0]    rd_data,
  output logic [REG_AW-1:0]    rd_addr,
  output mdio_state_e          st,
  output logic                 ta_second,
  output logic                 is_read,
  output logic                 shift_msb,
  output logic                 wr_en,
  output logic [REG_AW-1:0]    wr_addr,
  output logic [DATA_W-1:0]    wr_data
);
  localparam int PRE_W = $clog2(PRE_LEN + 1);
  localparam int CNT_W = $clog2(DATA_W + 3);
  localparam logic [PRE_W-1:0] PRE_FULL  = PRE_W'(PRE_LEN);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] SKIP_LAST = CNT_W'(DATA_W + 1);

  mdio_state_e        st_q, st_n;
  logic [PRE_W-1:0]   pre_q, pre_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [HDR_W-1:0]   hdr_q, hdr_n;
  logic [DATA_W-1:0]  sh_q, sh_n;
  logic               rd_q, rd_n;
  logic [HDR_W-1:0]   hdr_full;
  logic               hdr_ok;

  assign hdr_full = {hdr_q[HDR_W-2:0], mdio_in};
  assign hdr_ok   = (hdr_full[REG_AW +: PHY_AW] == phy_addr) &&
                    ((hdr_full[HDR_W-1 -: OP_W] == OP_READ) ||
                     (hdr_full[HDR_W-1 -: OP_W] == OP_WRITE));
  assign rd_addr  = hdr_full[REG_AW-1:0];

  always_comb begin
    st_n  = st_q;
    pre_n = pre_q;
    cnt_n = cnt_q;
    hdr_n = hdr_q;
    sh_n  = sh_q;
    rd_n  = rd_q;
    wr_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (mdio_in) begin
          if (pre_q != PRE_FULL) pre_n = pre_q + 1'b1;
        end else begin
          pre_n = '0;
          if (pre_q == PRE_FULL) st_n = ST_START;
        end
      end
      ST_START: begin
        cnt_n = '0;
        st_n  = mdio_in ? ST_HDR : ST_IDLE;
      end
      ST_HDR: begin
        hdr_n = hdr_full;
        cnt_n = cnt_q + 1'b1;
        if (cnt_q == HDR_LAST) begin
          cnt_n = '0;
          if (hdr_ok) begin
            st_n = ST_TA;
            rd_n = (hdr_full[HDR_W-1 -: OP_W] == OP_READ);
            sh_n = rd_data;
          end else begin
            st_n = ST_SKIP;
          end
        end
      end
      ST_TA: begin
        cnt_n = cnt_q + 1'b1;
        if (cnt_q != '0) begin
          cnt_n = '0;
          st_n  = ST_DATA;
        end
      end
      ST_DATA: begin
        sh_n  = {sh_q[DATA_W-2:0], mdio_in};
        cnt_n = cnt_q + 1'b1;
        if (cnt_q == DATA_LAST) begin
          st_n  = ST_IDLE;
          pre_n = '0;
          wr_en = !rd_q;
        end
      end
      ST_SKIP: begin
        cnt_n = cnt_q + 1'b1;
        if (cnt_q == SKIP_LAST) begin
          st_n  = ST_IDLE;
          pre_n = '0;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      pre_q <= '0;
      cnt_q <= '0;
      hdr_q <= '0;
      sh_q  <= '0;
      rd_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      pre_q <= pre_n;
      cnt_q <= cnt_n;
      hdr_q <= hdr_n;
      sh_q  <= sh_n;
      rd_q  <= rd_n;
    end
  end

  assign st        = st_q;
  assign ta_second = (st_q == ST_TA) && (cnt_q != '0);
  assign is_read   = rd_q;
  assign shift_msb = sh_q[DATA_W-1];
  assign wr_addr   = hdr_q[REG_AW-1:0];
  assign wr_data   = {sh_q[DATA_W-2:0], mdio_in};

  // R2: a zero seen before the preamble is complete keeps the parser idle
  p_short_preamble_r2: assert property (@(posedge mdc) disable iff (!rst_n)
    (st_q == ST_IDLE && !mdio_in && pre_q != PRE_FULL) |=> (st_q == ST_IDLE));

  // R7, R8: turnaround is only entered for a matching address and a valid opcode
  p_ta_needs_match_r7: assert property (@(posedge mdc) disable iff (!rst_n)
    (st_q == ST_TA) |-> (hdr_q[REG_AW +: PHY_AW] == phy_addr &&
      (hdr_q[HDR_W-1 -: OP_W] == OP_READ || hdr_q[HDR_W-1 -: OP_W] == OP_WRITE)));

  // R9: the parser is idle with a fresh preamble count right after the last data bit
  p_frame_end_r9: assert property (@(posedge mdc) disable iff (!rst_n)
    (st_q == ST_DATA && cnt_q == DATA_LAST) |=> (st_q == ST_IDLE && pre_q <= PRE_W'(1)));
endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
  import mdio_pkg::*;
#(
  parameter int          DATA_W    = 16,
  parameter logic [31:0] IMPL_MASK = 32'h0001_00FF
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int NUM_ADDR = 1 << REG_AW;

  logic [DATA_W-1:0]          regs [NUM_ADDR];
  logic [NUM_ADDR*DATA_W-1:0] regs_flat;

  for (genvar a = 0; a < NUM_ADDR; a++) begin : g_addr
    if (IMPL_MASK[a]) begin : g_impl
      logic [DATA_W-1:0] q;
      logic              we;
      assign we = wr_en && (wr_addr == REG_AW'(a));
      always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wr_data;
      end
      assign regs[a] = q;
    end else begin : g_hole
      assign regs[a] = '1;
    end
    assign regs_flat[a*DATA_W +: DATA_W] = regs[a];
  end

  assign rd_data = regs[rd_addr];

  // R6: a write to a hole changes no register
  p_unimpl_write_r6: assert property (@(posedge mdc) disable iff (!rst_n)
    (wr_en && !IMPL_MASK[wr_addr]) |=> $stable(regs_flat));

  // R4: a write to an implemented address lands in that register
  p_write_lands_r4: assert property (@(posedge mdc) disable iff (!rst_n)
    (wr_en && IMPL_MASK[wr_addr]) |=> (regs[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/mdio_drive.sv
module mdio_drive
  import mdio_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic        mdc,
  input  logic        rst_n,
  input  mdio_state_e st,
  input  logic        ta_second,
  input  logic        is_read,
  input  logic        shift_msb,
  output logic        mdio_out,
  output logic        mdio_oe
);
  localparam int RUN_W = $clog2(DATA_W + 3);

  logic oe_d, out_d, oe_q, out_q;

  always_comb begin
    oe_d  = is_read && (ta_second || st == ST_DATA);
    out_d = (st == ST_DATA) ? shift_msb : 1'b0;
  end

  always_ff @(negedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      out_q <= 1'b0;
    end else begin
      oe_q  <= oe_d;
      out_q <= out_d && oe_d;
    end
  end

  assign mdio_oe  = oe_q;
  assign mdio_out = out_q;

  // R3: the first driven bit of a read is the turnaround zero
  p_ta_zero_r3: assert property (@(negedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_out);

  logic [RUN_W-1:0] oe_run;
  always_ff @(negedge mdc or negedge rst_n) begin
    if (!rst_n)       oe_run <= '0;
    else if (oe_q)    oe_run <= oe_run + 1'b1;
    else              oe_run <= '0;
  end

  // R3: one read drives for the turnaround bit plus the data field, never longer
  p_drive_len_r3: assert property (@(negedge mdc) disable iff (!rst_n)
    oe_run <= RUN_W'(DATA_W + 1));
endmodule

// File: rtl/mdio_slave_top.sv
module mdio_slave_top
  import mdio_pkg::*;
#(
  parameter int          DATA_W    = 16,
  parameter int          PRE_LEN   = 32,
  parameter logic [31:0] IMPL_MASK = 32'h0001_00FF
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic [PHY_AW-1:0] phy_addr,
  input  logic              mdio_in,
  output logic              mdio_out,
  output logic              mdio_oe
);
  logic              rst_s;
  mdio_state_e       st;
  logic              ta_second, is_read, shift_msb, wr_en;
  logic [REG_AW-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  mdio_rst_sync #(.STAGES(2)) u_rst (
    .clk(mdc), .rst_n(rst_n), .rst_n_sync(rst_s)
  );

  mdio_frame_fsm #(.DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) u_fsm (
    .mdc(mdc), .rst_n(rst_s), .mdio_in(mdio_in), .phy_addr(phy_addr),
    .rd_data(rd_data), .rd_addr(rd_addr), .st(st), .ta_second(ta_second),
    .is_read(is_read), .shift_msb(shift_msb), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  mdio_reg_bank #(.DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK)) u_bank (
    .mdc(mdc), .rst_n(rst_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  mdio_drive #(.DATA_W(DATA_W)) u_drv (
    .mdc(mdc), .rst_n(rst_s), .st(st), .ta_second(ta_second),
    .is_read(is_read), .shift_msb(shift_msb),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );
endmodule

// File: tb/mdio_slave_top_tb.sv
module mdio_slave_top_tb_top;
  localparam logic [4:0] STRAP = 5'h03;
  localparam int NV = 14;

  logic mdc = 1'b0;
  logic rst_n = 1'b0;
  logic tb_drv = 1'b1;
  logic dut_out, dut_oe, bus;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 mdc = ~mdc;
  assign bus = dut_oe ? dut_out : tb_drv;

  mdio_slave_top dut_i (
    .mdc(mdc), .rst_n(rst_n), .phy_addr(STRAP),
    .mdio_in(bus), .mdio_out(dut_out), .mdio_oe(dut_oe)
  );

  // {op, phy, reg, wdata, expected read data, expect drive}
  localparam logic [44:0] VEC [NV] = '{
    {2'b01, 5'h03, 5'd1,  16'h1234, 16'h0000, 1'b0},  // R4 write
    {2'b10, 5'h03, 5'd1,  16'h0000, 16'h1234, 1'b1},  // R9 back-to-back readback
    {2'b01, 5'h03, 5'd16, 16'hBEEF, 16'h0000, 1'b0},  // R4 write
    {2'b10, 5'h03, 5'd16, 16'h0000, 16'hBEEF, 1'b1},  // R3 read
    {2'b01, 5'h03, 5'd9,  16'h5555, 16'h0000, 1'b0},  // R6 hole write
    {2'b10, 5'h03, 5'd9,  16'h0000, 16'hFFFF, 1'b1},  // R5 hole read
    {2'b01, 5'h04, 5'd2,  16'hAAAA, 16'h0000, 1'b0},  // R7 foreign write
    {2'b10, 5'h03, 5'd2,  16'h0000, 16'h0000, 1'b1},  // R7 reg 2 unchanged
    {2'b11, 5'h03, 5'd1,  16'h0F0F, 16'h0000, 1'b0},  // R8 opcode 11
    {2'b00, 5'h03, 5'd1,  16'h0F0F, 16'h0000, 1'b0},  // R8 opcode 00
    {2'b10, 5'h03, 5'd1,  16'h0000, 16'h1234, 1'b1},  // R6 reg 1 unchanged
    {2'b10, 5'h04, 5'd1,  16'h0000, 16'h0000, 1'b0},  // R7 foreign read
    {2'b01, 5'h03, 5'd7,  16'h8001, 16'h0000, 1'b0},  // R4 write
    {2'b10, 5'h03, 5'd7,  16'h0000, 16'h8001, 1'b1}   // R3 read msb first
  };
  localparam string TAG [NV] = '{"R4", "R9", "R4", "R3", "R6", "R5", "R7",
                                 "R7", "R8", "R8", "R6", "R7", "R4", "R3"};

  logic       s_oe, s_out;
  logic       any_drive, ta_ok;
  logic [15:0] got;

  task automatic put_bit(input logic b);
    @(negedge mdc);
    #2;
    tb_drv = b;
    s_oe  = dut_oe;
    s_out = dut_out;
    if (s_oe) any_drive = 1'b1;
  endtask

  task automatic frame(input int pre, input logic [1:0] op, input logic [4:0] phy,
                       input logic [4:0] rg, input logic [15:0] wd);
    any_drive = 1'b0;
    ta_ok = 1'b1;
    got = '0;
    for (int i = 0; i < pre; i++) put_bit(1'b1);
    put_bit(1'b0); put_bit(1'b1);
    for (int i = 1; i >= 0; i--) put_bit(op[i]);
    for (int i = 4; i >= 0; i--) put_bit(phy[i]);
    for (int i = 4; i >= 0; i--) put_bit(rg[i]);
    if (any_drive) ta_ok = 1'b0;
    put_bit(op == 2'b10 ? 1'b1 : 1'b1);
    if (s_oe) ta_ok = 1'b0;
    put_bit(op == 2'b10 ? 1'b1 : 1'b0);
    if (!(s_oe && !s_out)) ta_ok = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      put_bit(op == 2'b10 ? 1'b1 : wd[i]);
      got[i] = s_out;
      if (!s_oe) ta_ok = 1'b0;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge mdc);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (4) @(negedge mdc);
    check("R1 oe in reset", {31'd0, dut_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge mdc);
    check("R1 oe after reset", {31'd0, dut_oe}, 32'd0);

    // R1: implemented register reads zero after reset
    frame(32, 2'b10, STRAP, 5'd5, 16'h0);
    check("R1 reset value", {16'd0, got}, 32'h0000);
    check("R3 turnaround/drive", {31'd0, ta_ok}, 32'd1);

    // R2: 31 ones is not a preamble
    frame(31, 2'b10, STRAP, 5'd5, 16'h0);
    check("R2 short preamble no drive", {31'd0, any_drive}, 32'd0);

    // table walk, frames back to back (R9)
    for (int v = 0; v < NV; v++) begin
      frame(32, VEC[v][44:43], VEC[v][42:38], VEC[v][37:33], VEC[v][32:17]);
      if (VEC[v][0]) begin
        check({TAG[v], " read data"}, {16'd0, got}, {16'd0, VEC[v][16:1]});
        check({TAG[v], " turnaround/drive"}, {31'd0, ta_ok}, 32'd1);
      end else begin
        check({TAG[v], " no drive"}, {31'd0, any_drive}, 32'd0);
      end
    end

    // R3: line released in the bit after the last data bit
    put_bit(1'b1);
    check("R3 release", {31'd0, s_oe}, 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule